// File: doc/BRIEF.md
# Single-Master Bus Address Decoder and Response Return Path

This block is the central routing logic of a single-master AHB-Lite subsystem. In the address phase it compares a 4-bit module identifier and an 8-bit field taken from address bits [27:20] against a small map. It then drives one-hot select lines to the mapped slaves. If an address matches no slave, the transfer goes to a built-in default slave.

The choice of slave is stored into a data-phase select register, but only on a clock edge where the bus ready is high. This register steers the read data, ready and error response of the slave that owns the current data phase back to the master. The live address-phase decode does not steer that return path. The combined ready output goes to the master and is also fed back to every slave as its ready input. The write and read data paths are separate unidirectional buses, and there are no tri-state signals.

The default slave completes IDLE and BUSY transfers with an OKAY response and no wait state. It answers NONSEQ and SEQ transfers with a two-cycle ERROR response.

Top module: `ahbl_fabric`

## Requirements
- R1: Slave select line i (i = 0 to NUM_SLV-1) is high in the same cycle exactly when the module identifier equals 0xC and the address field equals 0x20 + i. Slave 0 is at field 0x20. At most one select line is high.
- R2: When the module identifier is not 0xC, or the field is outside 0x20 to 0x20+NUM_SLV-1, no select line is high and the transfer is routed to the default slave.
- R3: In the first cycle after reset the data phase belongs to the default slave. Ready is high, the error response is low and read data is zero.
- R4: In the cycle after an address phase is accepted with ready high to mapped slave i, read data, ready and error response equal the read data, ready and error of slave i. This holds until the next accepted address phase.
- R5: While ready is low, the data-phase routing does not change, whatever address is presented.
- R6: An IDLE (transfer code 2'b00) or BUSY (2'b01) transfer accepted to the default slave gives ready high and error low in the next cycle.
- R7: A NONSEQ (2'b10) or SEQ (2'b11) transfer accepted to the default slave gives ready low with error high in the next cycle. In the cycle after that it gives ready high with error high.
- R8: An active transfer to the default slave accepted in the second error cycle starts a new two-cycle error response at once.
- R9: While the default slave owns the data phase, read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| i_modid | input | 4 | Module identifier of the address phase |
| i_addr_field | input | 8 | Address bits [27:20] of the address phase |
| i_htrans | input | 2 | Transfer type of the address phase |
| o_hsel | output | NUM_SLV | One-hot slave selects, address phase |
| i_slv_rdata | input | NUM_SLV*DW | Read data of each slave, slave i at bits [i*DW +: DW] |
| i_slv_ready | input | NUM_SLV | Ready-out of each slave |
| i_slv_err | input | NUM_SLV | Error response of each slave |
| o_hrdata | output | DW | Read data to the master |
| o_hready | output | 1 | Ready to the master and to all slaves |
| o_hresp | output | 1 | Error response to the master |

## Verification
Select lines are combinational and are checked in the same cycle as the address and module identifier that cause them. Read data, ready and error follow from the address phase accepted at the previous rising edge with ready high. The default slave's error takes two cycles, with ready low in the first cycle and high in the second. The bench drives inputs on the falling edge and compares all outputs 1 ns later against a reference model. That model moves to its next state only at the rising edge, using the ready value it predicted for that cycle. Stalls, back-to-back errors and held addresses therefore keep the right alignment.

// File: rtl/ahbl_fabric_pkg.sv
package ahbl_fabric_pkg;

    localparam logic [3:0] LOCAL_MODID = 4'hC;
    localparam logic [7:0] MAP_BASE    = 8'h20;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } trans_e;

    typedef enum logic [1:0] {
        DS_OKAY     = 2'b00,
        DS_ERR_WAIT = 2'b01,
        DS_ERR_DONE = 2'b10
    } dflt_state_e;

    typedef struct packed {
        logic ready;
        logic err;
    } rsp_t;

    function automatic logic trans_active(input logic [1:0] t);
        return (trans_e'(t) == TR_NONSEQ) || (trans_e'(t) == TR_SEQ);
    endfunction

endpackage

// File: rtl/ahbl_addr_decode.sv
module ahbl_addr_decode
    import ahbl_fabric_pkg::*;
#(
    parameter int NUM_SLV = 3,
    parameter int FIELD_W = 8
) (
    input  logic [3:0]         i_modid,
    input  logic [FIELD_W-1:0] i_field,
    output logic [NUM_SLV-1:0] o_sel,
    output logic               o_miss
);
    logic id_ok;
    assign id_ok = (i_modid == LOCAL_MODID);

    for (genvar g = 0; g < NUM_SLV; g++) begin : g_region
        localparam logic [FIELD_W-1:0] REGION = FIELD_W'(int'(MAP_BASE) + g);
        assign o_sel[g] = id_ok && (i_field == REGION);
    end

    assign o_miss = ~|o_sel;
endmodule

// File: rtl/ahbl_default_slave.sv
module ahbl_default_slave
    import ahbl_fabric_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       i_sel,
    input  logic       i_hready,
    input  logic [1:0] i_htrans,
    output rsp_t       o_rsp
);
    dflt_state_e state_q, state_d;

    always_comb begin
        state_d = DS_OKAY;
        if (state_q == DS_ERR_WAIT)
            state_d = DS_ERR_DONE;
        else if (i_hready && i_sel && trans_active(i_htrans))
            state_d = DS_ERR_WAIT;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= DS_OKAY;
        else     state_q <= state_d;
    end

    assign o_rsp.ready = (state_q != DS_ERR_WAIT);
    assign o_rsp.err   = (state_q != DS_OKAY);
endmodule

// File: rtl/ahbl_return_mux.sv
module ahbl_return_mux
    import ahbl_fabric_pkg::*;
#(
    parameter int NUM_SLV = 3,
    parameter int DW      = 32
) (
    input  logic [NUM_SLV:0]      i_dsel,
    input  logic [NUM_SLV*DW-1:0] i_slv_rdata,
    input  logic [NUM_SLV-1:0]    i_slv_ready,
    input  logic [NUM_SLV-1:0]    i_slv_err,
    input  rsp_t                  i_dflt_rsp,
    output logic [DW-1:0]         o_rdata,
    output rsp_t                  o_rsp
);
    always_comb begin
        o_rdata   = '0;
        o_rsp     = '0;
        for (int k = 0; k < NUM_SLV; k++) begin
            if (i_dsel[k]) begin
                o_rdata   = o_rdata | i_slv_rdata[k*DW +: DW];
                o_rsp.ready = o_rsp.ready | i_slv_ready[k];
                o_rsp.err   = o_rsp.err   | i_slv_err[k];
            end
        end
        if (i_dsel[NUM_SLV]) begin
            o_rsp.ready = o_rsp.ready | i_dflt_rsp.ready;
            o_rsp.err   = o_rsp.err   | i_dflt_rsp.err;
        end
    end
endmodule

// File: rtl/ahbl_fabric.sv
module ahbl_fabric
    import ahbl_fabric_pkg::*;
#(
    parameter int NUM_SLV = 3,
    parameter int DW      = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [3:0]            i_modid,
    input  logic [7:0]            i_addr_field,
    input  logic [1:0]            i_htrans,
    output logic [NUM_SLV-1:0]    o_hsel,
    input  logic [NUM_SLV*DW-1:0] i_slv_rdata,
    input  logic [NUM_SLV-1:0]    i_slv_ready,
    input  logic [NUM_SLV-1:0]    i_slv_err,
    output logic [DW-1:0]         o_hrdata,
    output logic                  o_hready,
    output logic                  o_hresp
);
    localparam int DSEL_W = NUM_SLV + 1;
    localparam logic [DSEL_W-1:0] DSEL_DFLT = DSEL_W'(1) << NUM_SLV;

    logic              miss;
    logic [DSEL_W-1:0] dsel_q;
    rsp_t              dflt_rsp;
    rsp_t              bus_rsp;

    ahbl_addr_decode #(.NUM_SLV(NUM_SLV), .FIELD_W(8)) u_dec (
        .i_modid (i_modid),
        .i_field (i_addr_field),
        .o_sel   (o_hsel),
        .o_miss  (miss)
    );

    // data-phase owner: advances only when the bus accepts a new address phase
    always_ff @(posedge clk) begin
        if (rst)           dsel_q <= DSEL_DFLT;
        else if (o_hready) dsel_q <= {miss, o_hsel};
    end

    ahbl_default_slave u_dflt (
        .clk      (clk),
        .rst      (rst),
        .i_sel    (miss),
        .i_hready (o_hready),
        .i_htrans (i_htrans),
        .o_rsp    (dflt_rsp)
    );

    ahbl_return_mux #(.NUM_SLV(NUM_SLV), .DW(DW)) u_mux (
        .i_dsel      (dsel_q),
        .i_slv_rdata (i_slv_rdata),
        .i_slv_ready (i_slv_ready),
        .i_slv_err   (i_slv_err),
        .i_dflt_rsp  (dflt_rsp),
        .o_rdata     (o_hrdata),
        .o_rsp       (bus_rsp)
    );

    assign o_hready = bus_rsp.ready;
    assign o_hresp  = bus_rsp.err;
endmodule

// File: rtl/ahbl_fabric_chk.sv
module ahbl_fabric_chk #(
    parameter int NUM_SLV = 3,
    parameter int DW      = 32
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SLV-1:0] o_hsel,
    input logic [1:0]         i_htrans,
    input logic [NUM_SLV:0]   dsel_q,
    input logic [DW-1:0]      o_hrdata,
    input logic               o_hready,
    input logic               o_hresp
);
    p_sel_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(o_hsel));

    p_reset_idle_r3: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (o_hready && !o_hresp && o_hrdata == '0));

    p_stall_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !o_hready |=> $stable(dsel_q));

    p_idle_okay_r6: assert property (@(posedge clk) disable iff (rst)
        (o_hready && o_hsel == '0 && !i_htrans[1]) |=> (o_hready && !o_hresp));

    p_err_start_r7: assert property (@(posedge clk) disable iff (rst)
        (o_hready && o_hsel == '0 && i_htrans[1]) |=> (!o_hready && o_hresp));

    p_err_finish_r7: assert property (@(posedge clk) disable iff (rst)
        (dsel_q[NUM_SLV] && !o_hready) |=> (o_hready && o_hresp));

    p_dflt_zero_r9: assert property (@(posedge clk) disable iff (rst)
        dsel_q[NUM_SLV] |-> (o_hrdata == '0));
endmodule

bind ahbl_fabric ahbl_fabric_chk #(.NUM_SLV(NUM_SLV), .DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .o_hsel   (o_hsel),
    .i_htrans (i_htrans),
    .dsel_q   (dsel_q),
    .o_hrdata (o_hrdata),
    .o_hready (o_hready),
    .o_hresp  (o_hresp)
);

// File: tb/ahbl_fabric_tb.sv
`timescale 1ns/1ps
module ahbl_fabric_tb;
    localparam int NS = 3;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0]       modid = '0;
    logic [7:0]       field = '0;
    logic [1:0]       htrans = '0;
    logic [NS-1:0]    hsel;
    logic [NS*DW-1:0] srdata = '0;
    logic [NS-1:0]    srdy = '1;
    logic [NS-1:0]    serr = '0;
    logic [DW-1:0]    hrdata;
    logic             hready, hresp;

    always #2.5 clk = ~clk;

    ahbl_fabric #(.NUM_SLV(NS), .DW(DW)) u_dut (
        .clk(clk), .rst(rst), .i_modid(modid), .i_addr_field(field),
        .i_htrans(htrans), .o_hsel(hsel), .i_slv_rdata(srdata),
        .i_slv_ready(srdy), .i_slv_err(serr), .o_hrdata(hrdata),
        .o_hready(hready), .o_hresp(hresp));

    int checks = 0, failures = 0, stepno = 0;
    bit done = 0;
    int m_owner = NS;   // NS stands for the default slave
    int m_dstate = 0;   // 0 okay, 1 first error cycle, 2 second error cycle

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h (step %0d)", tag, what, act, exp, stepno);
        end
    endtask

    task automatic step(input logic [3:0] mid, input logic [7:0] fld, input logic [1:0] tr,
                        input logic [NS-1:0] rdy, input logic [NS-1:0] err, input string tag);
        logic [NS-1:0] e_sel;
        logic e_rdy, e_err, hit;
        logic [31:0] e_rd;
        int tgt;
        @(negedge clk);
        stepno++;
        modid = mid; field = fld; htrans = tr; srdy = rdy; serr = err;
        for (int i = 0; i < NS; i++)
            srdata[i*DW +: DW] = {8'(8'hA0 + i), 16'h5A5A, 8'(stepno)};
        #1;
        e_sel = '0; tgt = NS;
        for (int i = 0; i < NS; i++)
            if (mid == 4'hC && fld == 8'(8'h20 + i)) begin e_sel[i] = 1'b1; tgt = i; end
        if (m_owner == NS) begin
            e_rdy = (m_dstate != 1); e_err = (m_dstate != 0); e_rd = '0;
        end else begin
            e_rdy = rdy[m_owner]; e_err = err[m_owner];
            e_rd = {8'(8'hA0 + m_owner), 16'h5A5A, 8'(stepno)};
        end
        hit = (tgt != NS);
        chk(tag, "hsel (R1/R2)", 32'(hsel), 32'(e_sel));
        chk(tag, "hready (R4)", 32'(hready), 32'(e_rdy));
        chk(tag, "hresp (R4)", 32'(hresp), 32'(e_err));
        chk(tag, "hrdata (R4/R9)", hrdata, e_rd);
        @(posedge clk);
        if (m_dstate == 1) m_dstate = 2;
        else if (e_rdy && !hit && tr[1]) m_dstate = 1;
        else m_dstate = 0;
        if (e_rdy) m_owner = tgt;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R3", "hready after reset", 32'(hready), 32'd1);
        chk("R3", "hresp after reset", 32'(hresp), 32'd0);
        chk("R3", "hrdata after reset", hrdata, 32'd0);
        // mapped slaves
        step(4'hC, 8'h20, 2'b00, 3'b111, 3'b000, "R1");
        step(4'hC, 8'h20, 2'b10, 3'b111, 3'b000, "R4");
        step(4'hC, 8'h21, 2'b10, 3'b111, 3'b000, "R4");
        step(4'hC, 8'h22, 2'b11, 3'b111, 3'b000, "R1");
        step(4'hC, 8'h22, 2'b00, 3'b111, 3'b100, "R4");
        // misses
        step(4'hB, 8'h20, 2'b10, 3'b111, 3'b000, "R2");
        step(4'hB, 8'h20, 2'b10, 3'b111, 3'b000, "R7");
        step(4'hC, 8'h23, 2'b00, 3'b111, 3'b000, "R7");
        step(4'hC, 8'h23, 2'b01, 3'b111, 3'b000, "R6");
        step(4'hC, 8'h1F, 2'b00, 3'b111, 3'b000, "R6");
        // back-to-back errors
        step(4'h0, 8'h00, 2'b10, 3'b111, 3'b000, "R8");
        step(4'h0, 8'h00, 2'b11, 3'b111, 3'b000, "R8");
        step(4'h0, 8'h00, 2'b11, 3'b111, 3'b000, "R8");
        step(4'h0, 8'h00, 2'b00, 3'b111, 3'b000, "R8");
        step(4'hC, 8'h21, 2'b10, 3'b111, 3'b000, "R9");
        // stall on slave 1 while another address is shown
        step(4'hC, 8'h22, 2'b10, 3'b101, 3'b000, "R5");
        step(4'hC, 8'h20, 2'b10, 3'b101, 3'b000, "R5");
        step(4'h3, 8'h77, 2'b10, 3'b101, 3'b010, "R5");
        step(4'hC, 8'h22, 2'b10, 3'b111, 3'b000, "R5");
        step(4'hC, 8'h22, 2'b00, 3'b111, 3'b000, "R4");
        // mixed traffic
        lf = 16'hACE1;
        for (int n = 0; n < 60; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[0] ? 4'hC : 4'h5, 8'h1F + 8'(lf[3:2]) + 8'(lf[4]), lf[6:5],
                 {lf[9] | lf[8], lf[10] | lf[7], lf[11] | lf[12]}, {lf[13], 1'b0, lf[14]},
                 "R1/R4/R6/R7");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule